// File: doc/BRIEF.md
# Byte-Addressed Load/Store Aligner

This block sits between a 32-bit processor core and a data memory that is organised in 32-bit words but addressed by byte. For each access request it adds a 16-bit signed displacement to a base address, produces the word-aligned memory address, and works out which of the four byte lanes the access touches. For stores it also spreads the store data across the lanes so that the memory only needs to honour the byte-enables. Lanes are numbered big-endian: byte offset 0 is bits 31:24 and the matching enable is bit 3.

For loads, the block keeps the lane, size and extension choice of the latest request. When the memory returns the read word, the block picks the addressed byte or halfword out of it and widens it to 32 bits with either sign or zero extension. A halfword access at an odd address, or a word access at an address that is not a multiple of 4, is flagged as misaligned. Such an access enables no lanes, does not write, and returns zero as load data.

Top module: `lsa_top`

## Requirements
- R1: One cycle after a request, `mem_addr` equals (base + sign-extended offset) modulo 2^32 with bits 1:0 cleared, and `out_valid` is high for exactly that cycle.
- R2: A byte store (size code 2'b00) at byte offset k enables exactly one lane: `mem_be` = 4'b1000 >> k.
- R3: A halfword store (size code 2'b01) at offset 0 gives `mem_be` = 4'b1100, and at offset 2 gives 4'b0011.
- R4: A word store (size code 2'b10, and reserved code 2'b11 treated the same) at offset 0 gives `mem_be` = 4'b1111.
- R5: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, drives `misaligned` high, `mem_be` to 0 and `mem_write` low. The load data for such an access is 0.
- R6: For stores, `mem_wdata` repeats the low byte four times for byte size, repeats the low halfword twice for halfword size, and passes the word unchanged for word size.
- R7: A load request (`req_store` low) drives `mem_be` to 0 and `mem_write` low.
- R8: A byte load with `req_zext` low returns byte lane k (bits 31-8k down to 24-8k) of the read word, sign-extended to 32 bits.
- R9: A byte or halfword load with `req_zext` high zero-extends the selected field.
- R10: A halfword load at offset 0 selects bits 31:16, and at offset 2 selects bits 15:0, sign-extended unless `req_zext` is high.
- R11: A word load returns the read word unchanged. `load_valid` and `load_data` follow `rsp_valid` by one cycle and use the lane, size and extension of the latest request.
- R12: After reset, `out_valid`, `load_valid`, `mem_write`, `misaligned` and `mem_be` are all 0.
- R13: Address arithmetic wraps modulo 2^32 for both positive and negative offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| req_zext | input | 1 | Load extension: 1 = zero, 0 = sign |
| req_base | input | 32 | Base address |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | input | 1 | Memory read word present |
| rsp_word | input | 32 | Memory read word |
| out_valid | output | 1 | Memory-side outputs valid |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_write | output | 1 | Store that is not misaligned |
| misaligned | output | 1 | Misaligned access flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The request path has a single register, so the address, enables, write data and misalignment flag of a request driven before clock edge n can be seen just after edge n. The load result has its own register, so it appears one edge after the read word is presented. The driver pushes each expected result into a queue when it drives the matching stimulus. The monitor samples on the falling edge, pops an entry only while `out_valid` or `load_valid` is high, and so compares every result in the cycle it is due.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int OFF_W  = 16;
    localparam int LANES      = DATA_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] word_addr;
        logic [LANES-1:0]  be;
        logic              misaligned;
    } lane_plan_t;

    typedef struct packed {
        acc_size_e             size;
        logic                  zext;
        logic [LANE_IDX_W-1:0] lane;
        logic                  misaligned;
    } load_ctx_t;

    function automatic logic is_wide(acc_size_e s);
        return (s == SZ_WORD) || (s == SZ_RSVD);
    endfunction

    function automatic logic check_misalign(acc_size_e s, logic [LANE_IDX_W-1:0] lane);
        if (s == SZ_HALF) return lane[0];
        if (is_wide(s))   return lane != '0;
        return 1'b0;
    endfunction
endpackage

// File: rtl/lsa_agu.sv
module lsa_agu
    import lsa_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    output logic [LANE_IDX_W-1:0] lane,
    output lane_plan_t        plan
);
    logic [ADDR_W-1:0] eff;
    logic [LANES-1:0]  raw_be;
    logic              mis;

    always_comb begin
        eff  = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        lane = eff[LANE_IDX_W-1:0];
        mis  = check_misalign(size, lane);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: raw_be[LANES-1-i] = (lane == LANE_IDX_W'(i));
                SZ_HALF: raw_be[LANES-1-i] = (lane[LANE_IDX_W-1:1] == (LANE_IDX_W-1)'(i / 2));
                default: raw_be[LANES-1-i] = 1'b1;
            endcase
        end
    end

    always_comb begin
        plan.word_addr = {eff[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
        plan.misaligned = mis;
        plan.be = mis ? '0 : raw_be;
    end
endmodule

// File: rtl/lsa_store_rep.sv
module lsa_store_rep
    import lsa_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] wdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[DATA_W-1-8*i -: 8] = data[7:0];
                SZ_HALF: wdata[DATA_W-1-8*i -: 8] = (i % 2 == 0) ? data[15:8] : data[7:0];
                default: wdata[DATA_W-1-8*i -: 8] = data[DATA_W-1-8*i -: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
    import lsa_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  load_ctx_t         ctx,
    output logic [DATA_W-1:0] data
);
    logic [LANE_IDX_W-1:0] rev_b;
    logic [LANE_IDX_W-1:0] rev_h;
    logic [DATA_W-1:0]     sh_b;
    logic [DATA_W-1:0]     sh_h;
    logic [7:0]            fb;
    logic [15:0]           fh;

    always_comb begin
        rev_b = LANE_IDX_W'(LANES - 1) - ctx.lane;
        rev_h = LANE_IDX_W'(LANES - 2) - ctx.lane;
        sh_b  = word >> {rev_b, 3'b000};
        sh_h  = word >> {rev_h, 3'b000};
        fb    = sh_b[7:0];
        fh    = sh_h[15:0];
        if (ctx.misaligned) begin
            data = '0;
        end else begin
            unique case (ctx.size)
                SZ_BYTE: data = {{(DATA_W-8){fb[7] & ~ctx.zext}}, fb};
                SZ_HALF: data = {{(DATA_W-16){fh[15] & ~ctx.zext}}, fh};
                default: data = word;
            endcase
        end
    end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_store,
    input  logic [1:0]  req_size,
    input  logic        req_zext,
    input  logic [31:0] req_base,
    input  logic [15:0] req_offset,
    input  logic [31:0] req_wdata,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_word,
    output logic        out_valid,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    output logic        mem_write,
    output logic        misaligned,
    output logic        load_valid,
    output logic [31:0] load_data
);
    acc_size_e             size_in;
    logic [LANE_IDX_W-1:0] lane;
    lane_plan_t            plan;
    logic [DATA_W-1:0]     rep_data;
    logic [DATA_W-1:0]     ext_data;
    load_ctx_t             ctx_q;

    assign size_in = acc_size_e'(req_size);

    lsa_agu u_agu (
        .base   (req_base),
        .offset (req_offset),
        .size   (size_in),
        .lane   (lane),
        .plan   (plan)
    );

    lsa_store_rep u_rep (
        .data  (req_wdata),
        .size  (size_in),
        .wdata (rep_data)
    );

    lsa_load_ext u_ext (
        .word (rsp_word),
        .ctx  (ctx_q),
        .data (ext_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            mem_addr   <= '0;
            mem_be     <= '0;
            mem_wdata  <= '0;
            mem_write  <= 1'b0;
            misaligned <= 1'b0;
            ctx_q      <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                mem_addr   <= plan.word_addr;
                mem_be     <= req_store ? plan.be : '0;
                mem_wdata  <= rep_data;
                mem_write  <= req_store & ~plan.misaligned;
                misaligned <= plan.misaligned;
                ctx_q      <= '{size: size_in, zext: req_zext, lane: lane,
                                misaligned: plan.misaligned};
            end else begin
                mem_be    <= '0;
                mem_write <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_valid <= 1'b0;
            load_data  <= '0;
        end else begin
            load_valid <= rsp_valid;
            if (rsp_valid) load_data <= ext_data;
        end
    end

    a_r5_misalign_no_lanes: assert property (@(posedge clk) disable iff (rst)
        (out_valid && misaligned) |-> (mem_be == '0 && !mem_write));

    a_r7_load_no_lanes: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store) |=> (mem_be == '0 && !mem_write));

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    a_r6_byte_replicated: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store && req_size == 2'b00) |=>
        (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0]
         && mem_wdata[15:8] == mem_wdata[7:0]));

    a_r9_zero_ext_byte: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ctx_q.zext && ctx_q.size == SZ_BYTE) |=> (load_data[31:8] == '0));
endmodule

// File: tb/lsa_top_test.sv
module lsa_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_zext, rsp_valid;
    logic [1:0]  req_size;
    logic [31:0] req_base, req_wdata, rsp_word;
    logic [15:0] req_offset;
    logic        out_valid, mem_write, misaligned, load_valid;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic [3:0]  mem_be;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] q_addr[$];
    logic [3:0]  q_be[$];
    logic [31:0] q_wd[$];
    logic        q_we[$];
    logic        q_mis[$];
    string       q_tag[$];
    logic [31:0] q_ld[$];
    string       q_ltag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_zext(req_zext), .req_base(req_base),
        .req_offset(req_offset), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_word(rsp_word), .out_valid(out_valid), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_write(mem_write),
        .misaligned(misaligned), .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] eff_addr(logic [31:0] b, logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    function automatic logic exp_mis(logic [1:0] sz, logic [1:0] k);
        if (sz == 2'b01) return k[0];
        if (sz[1])       return k != 2'b00;
        return 1'b0;
    endfunction

    task automatic issue(logic st, logic [1:0] sz, logic zx, logic [31:0] b,
                         logic [15:0] o, logic [31:0] d, string tag);
        logic [31:0] e;
        logic [1:0]  k;
        logic        m;
        logic [3:0]  be;
        logic [31:0] wd;
        e = eff_addr(b, o);
        k = e[1:0];
        m = exp_mis(sz, k);
        case (sz)
            2'b00: begin be = 4'b1000 >> k; wd = {4{d[7:0]}}; end
            2'b01: begin be = (k == 2'b00) ? 4'b1100 : 4'b0011; wd = {2{d[15:0]}}; end
            default: begin be = 4'b1111; wd = d; end
        endcase
        if (m || !st) be = 4'b0000;
        @(negedge clk);
        req_valid = 1; req_store = st; req_size = sz; req_zext = zx;
        req_base = b; req_offset = o; req_wdata = d;
        q_addr.push_back({e[31:2], 2'b00}); q_be.push_back(be);
        q_wd.push_back(st ? wd : 32'h0); q_we.push_back(st & ~m);
        q_mis.push_back(m); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_load(logic [1:0] sz, logic zx, logic [31:0] b, logic [15:0] o,
                           logic [31:0] w, string tag);
        logic [1:0]  k;
        logic [7:0]  fb;
        logic [15:0] fh;
        logic [31:0] x;
        k = eff_addr(b, o)[1:0];
        issue(1'b0, sz, zx, b, o, 32'h0, tag);
        fb = w[31 - 8*k -: 8];
        fh = k[1] ? w[15:0] : w[31:16];
        case (sz)
            2'b00: x = zx ? {24'h0, fb} : {{24{fb[7]}}, fb};
            2'b01: x = zx ? {16'h0, fh} : {{16{fh[15]}}, fh};
            default: x = w;
        endcase
        if (exp_mis(sz, k)) x = 32'h0;
        rsp_valid = 1; rsp_word = w;
        q_ld.push_back(x); q_ltag.push_back(tag);
        @(negedge clk);
        rsp_valid = 0;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_tag.size() == 0) begin
                    chk("R1 unexpected out_valid", 32'h1, 32'h0);
                end else begin
                    string t;
                    logic we;
                    t = q_tag.pop_front();
                    we = q_we.pop_front();
                    chk({t, " addr"}, mem_addr, q_addr.pop_front());
                    chk({t, " be"}, {28'h0, mem_be}, {28'h0, q_be.pop_front()});
                    chk({t, " write"}, {31'h0, mem_write}, {31'h0, we});
                    chk({t, " misaligned"}, {31'h0, misaligned}, {31'h0, q_mis.pop_front()});
                    if (we) chk({t, " wdata"}, mem_wdata, q_wd.pop_front());
                    else void'(q_wd.pop_front());
                end
            end
            if (load_valid) begin
                if (q_ltag.size() == 0) chk("R11 unexpected load_valid", 32'h1, 32'h0);
                else chk({q_ltag.pop_front(), " load_data"}, load_data, q_ld.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_store = 0; req_size = 0; req_zext = 0;
        req_base = 0; req_offset = 0; req_wdata = 0; rsp_valid = 0; rsp_word = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R12 out_valid", {31'h0, out_valid}, 32'h0);
        chk("R12 load_valid", {31'h0, load_valid}, 32'h0);
        chk("R12 mem_write", {31'h0, mem_write}, 32'h0);
        chk("R12 misaligned", {31'h0, misaligned}, 32'h0);
        chk("R12 mem_be", {28'h0, mem_be}, 32'h0);

        for (int k = 0; k < 4; k++)
            issue(1, 2'b00, 0, 32'h0000_1000, 16'(k), 32'hDEAD_BEA5, "R2 R6 byte store");
        issue(1, 2'b01, 0, 32'h0000_2000, 16'h0000, 32'h1234_C3D4, "R3 R6 half store off0");
        issue(1, 2'b01, 0, 32'h0000_2000, 16'h0002, 32'h1234_C3D4, "R3 half store off2");
        issue(1, 2'b01, 0, 32'h0000_2000, 16'h0001, 32'h1234_C3D4, "R5 half store odd");
        issue(1, 2'b10, 0, 32'h0000_3000, 16'h0010, 32'hCAFE_F00D, "R4 R6 word store");
        issue(1, 2'b11, 0, 32'h0000_3000, 16'h0014, 32'h0BAD_CAFE, "R4 reserved size store");
        issue(1, 2'b10, 0, 32'h0000_3000, 16'h0002, 32'hCAFE_F00D, "R5 word store off2");
        issue(1, 2'b10, 0, 32'h0000_3000, 16'h0003, 32'hCAFE_F00D, "R5 word store off3");
        issue(1, 2'b00, 0, 32'h0000_0100, 16'hFFF7, 32'h0000_0077, "R1 R13 negative offset");
        issue(1, 2'b10, 0, 32'hFFFF_FFF8, 16'h0010, 32'h1111_2222, "R13 wrap high");
        issue(1, 2'b00, 0, 32'h0000_0002, 16'hFFFC, 32'h0000_0099, "R13 wrap low");
        issue(0, 2'b10, 0, 32'h0000_4000, 16'h0000, 32'hFFFF_FFFF, "R7 load no lanes");

        for (int k = 0; k < 4; k++) begin
            do_load(2'b00, 0, 32'h0000_5000, 16'(k), 32'h80_7F_C1_05, "R8 signed byte load");
            do_load(2'b00, 1, 32'h0000_5000, 16'(k), 32'h80_7F_C1_05, "R9 unsigned byte load");
        end
        do_load(2'b01, 0, 32'h0000_6000, 16'h0000, 32'h8001_7FFE, "R10 signed half off0");
        do_load(2'b01, 0, 32'h0000_6000, 16'h0002, 32'h7001_9FFE, "R10 signed half off2");
        do_load(2'b01, 1, 32'h0000_6000, 16'h0000, 32'h8001_7FFE, "R9 R10 unsigned half");
        do_load(2'b10, 0, 32'h0000_6000, 16'h0004, 32'h89AB_CDEF, "R11 word load");
        do_load(2'b10, 0, 32'h0000_6000, 16'h0001, 32'h89AB_CDEF, "R5 misaligned word load");
        do_load(2'b01, 1, 32'h0000_6000, 16'h0003, 32'h89AB_CDEF, "R5 misaligned half load");

        repeat (3) @(negedge clk);
        chk("R1 outstanding requests", q_tag.size(), 0);
        chk("R11 outstanding loads", q_ltag.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule